// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a microcoded processor. The opcode of the current instruction is looked up in a dispatch table. The table returns the first micro-address of that instruction's routine. The micro-address counter loads this value, and the micro-word stored there is registered into the micro-instruction register. That register drives the control word towards the datapath. A sequencing field in the same word picks the next micro-address in the same cycle. The choices are the next address, a jump target held in the word, or a jump that is taken only when a chosen ALU flag is set. The last choice is a return to the dispatch table.

Both the micro-store and the dispatch table are plain arrays filled through write ports, normally while reset is held. After reset the counter starts at address 0, which is expected to hold the fetch routine. When a routine ends, the block raises a one-cycle done pulse. If an instruction is already presented, it dispatches that instruction at once. Otherwise it idles with a quiet control word until the instruction-valid strobe arrives.

Top module: `micro_sequencer`

## Requirements
- R1: While reset is held the control word is zero and done is low; in the first cycle after release the word at micro-address 0 is executed.
- R2: Sequencing code 00 (bits [1:0]) executes the word at the current address plus one in the next cycle.
- R3: Code 01 executes the word at the target field (bits [9:4]) in the next cycle.
- R4: Code 10 jumps to the target when the flag chosen by bits [3:2] is set: 00 zero (aluFlags[0]), 01 carry (aluFlags[1]), 10 negative (aluFlags[2]).
- R5: Code 10 with the chosen flag clear, or with selector 11, behaves as code 00.
- R6: Code 11 marks the routine's last word: done is high for exactly the cycle that word drives the control word.
- R7: If instrValid is high during a last-word cycle, the routine at dispatch[opcode] runs in the very next cycle.
- R8: If instrValid is low during a last-word cycle, the block idles with control word zero and done low until instrValid is seen, and then runs dispatch[opcode] in the next cycle.
- R9: instrValid and opcode are ignored while a word other than a last word is executing.
- R10: A micro-word holds the control bits in [17:10]. Writes through the store and dispatch ports set the words and start addresses that are later executed.
- R11: Incrementing past the top micro-address wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instrValid | input | 1 | A new instruction opcode is presented |
| opcode | input | 4 | Opcode from the instruction register |
| aluFlags | input | 3 | {negative, carry, zero} status flags |
| storeWrEn | input | 1 | Micro-store write enable |
| storeWrAddr | input | 6 | Micro-store write address |
| storeWrData | input | 18 | Micro-word to write |
| mapWrEn | input | 1 | Dispatch table write enable |
| mapWrAddr | input | 4 | Dispatch table entry (opcode) |
| mapWrData | input | 6 | Routine start address to write |
| ctrlWord | output | 8 | Control word to the datapath |
| instrDone | output | 1 | One-cycle pulse on a routine's last word |

## Verification
The routines in the test program are chosen so that each sequencing code leads to a different address. A wrong choice therefore shows up as a wrong control word in the following cycle. The conditional routines run with each flag set and clear. This separates taken from not-taken branches, shows that each selector reads its own flag, and shows that selector 11 never branches. Routines are started three ways: from the idle state, back to back with instrValid held high, and with a stray valid pulse in the middle of a routine. These cases separate immediate dispatch, idle waiting and ignored strobes. A routine placed at the top address checks the counter wrap into the fetch routine.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Sequencing codes carried in bits [1:0] of every micro-word
  typedef enum logic [1:0] {
    SEQ_INC = 2'b00,
    SEQ_JMP = 2'b01,
    SEQ_BRF = 2'b10,
    SEQ_END = 2'b11
  } seqOp_e;

  // Source of the next micro-address
  typedef enum logic [1:0] {
    NX_HOLD = 2'd0,
    NX_INC  = 2'd1,
    NX_JUMP = 2'd2,
    NX_MAP  = 2'd3
  } nextSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    nextSel_e sel;
    logic     drive;
  } seqStrobe_t;

  localparam int FLAG_COUNT = 3;

endpackage

// File: rtl/useq_dp.sv
module useq_dp
  import useq_pkg::*;
#(
  parameter int OPC_W   = 4,
  parameter int UADDR_W = 6,
  parameter int CTRL_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  seqStrobe_t                 strobe,
  input  logic [OPC_W-1:0]           opcode,
  input  logic                       storeWrEn,
  input  logic [UADDR_W-1:0]         storeWrAddr,
  input  logic [CTRL_W+UADDR_W+3:0]  storeWrData,
  input  logic                       mapWrEn,
  input  logic [OPC_W-1:0]           mapWrAddr,
  input  logic [UADDR_W-1:0]         mapWrData,
  output seqOp_e                     seqOp,
  output logic [1:0]                 flagSel,
  output logic [CTRL_W-1:0]          ctrlField
);

  localparam int SEQ_LSB     = 0;
  localparam int FSEL_LSB    = 2;
  localparam int TGT_LSB     = 4;
  localparam int CTRL_LSB    = TGT_LSB + UADDR_W;
  localparam int WORD_W      = CTRL_LSB + CTRL_W;
  localparam int STORE_DEPTH = 1 << UADDR_W;
  localparam int MAP_DEPTH   = 1 << OPC_W;

  logic [WORD_W-1:0]  store  [STORE_DEPTH];
  logic [UADDR_W-1:0] mapTbl [MAP_DEPTH];

  logic [UADDR_W-1:0] uPc, nextAddr, target, mapStart;
  logic [WORD_W-1:0]  uIr;

  always_ff @(posedge clk) begin
    if (storeWrEn) store[storeWrAddr] <= storeWrData;
  end

  always_ff @(posedge clk) begin
    if (mapWrEn) mapTbl[mapWrAddr] <= mapWrData;
  end

  assign target    = uIr[TGT_LSB +: UADDR_W];
  assign mapStart  = mapTbl[opcode];
  assign seqOp     = seqOp_e'(uIr[SEQ_LSB +: 2]);
  assign flagSel   = uIr[FSEL_LSB +: 2];
  assign ctrlField = uIr[CTRL_LSB +: CTRL_W];

  always_comb begin
    unique case (strobe.sel)
      NX_INC:  nextAddr = uPc + UADDR_W'(1);
      NX_JUMP: nextAddr = target;
      NX_MAP:  nextAddr = mapStart;
      default: nextAddr = uPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uPc <= '0;
      uIr <= '0;
    end else begin
      uPc <= nextAddr;
      uIr <= store[nextAddr];
    end
  end

  // R2 / R11: increment advances by one, wrapping at the top
  p_inc_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.sel == NX_INC |=> uPc == $past(uPc) + UADDR_W'(1));

  // R3 / R4: a jump lands on the target field of the previous word
  p_jump_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.sel == NX_JUMP |=> uPc == $past(target));

  // R7 / R8: dispatch lands on the table entry of the sampled opcode
  p_map_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.sel == NX_MAP |=> uPc == $past(mapStart));

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  instrValid,
  input  logic [FLAG_COUNT-1:0] aluFlags,
  input  seqOp_e                seqOp,
  input  logic [1:0]            flagSel,
  output seqStrobe_t            strobe,
  output logic                  instrDone
);

  typedef enum logic [1:0] {ST_PRIME, ST_RUN, ST_WAIT} state_e;
  state_e state, stateNxt;
  logic   flagHit;

  always_comb begin
    unique case (flagSel)
      2'b00:   flagHit = aluFlags[0];
      2'b01:   flagHit = aluFlags[1];
      2'b10:   flagHit = aluFlags[2];
      default: flagHit = 1'b0;
    endcase
  end

  always_comb begin
    strobe.sel   = NX_HOLD;
    strobe.drive = 1'b0;
    instrDone    = 1'b0;
    stateNxt     = state;
    unique case (state)
      ST_PRIME: stateNxt = ST_RUN;
      ST_RUN: begin
        strobe.drive = 1'b1;
        unique case (seqOp)
          SEQ_INC: strobe.sel = NX_INC;
          SEQ_JMP: strobe.sel = NX_JUMP;
          SEQ_BRF: strobe.sel = flagHit ? NX_JUMP : NX_INC;
          default: begin
            instrDone = 1'b1;
            if (instrValid) strobe.sel = NX_MAP;
            else            stateNxt   = ST_WAIT;
          end
        endcase
      end
      default: begin
        if (instrValid) begin
          strobe.sel = NX_MAP;
          stateNxt   = ST_RUN;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_PRIME;
    else     state <= stateNxt;
  end

  // R1: the priming cycle after reset always leads into execution
  p_prime_run_r1: assert property (@(posedge clk) disable iff (rst)
    state == ST_PRIME |=> state == ST_RUN);

  // R6: done only while a routine word is being executed
  p_done_run_r6: assert property (@(posedge clk) disable iff (rst)
    instrDone |-> state == ST_RUN && !strobe.drive == 1'b0);

  // R8: idle persists, silently, until instrValid
  p_wait_hold_r8: assert property (@(posedge clk) disable iff (rst)
    state == ST_WAIT && !instrValid |=> state == ST_WAIT && !instrDone);

  // R8: a last word without valid parks the sequencer
  p_end_park_r8: assert property (@(posedge clk) disable iff (rst)
    instrDone && !instrValid |=> state == ST_WAIT);

endmodule

// File: rtl/micro_sequencer.sv
module micro_sequencer
  import useq_pkg::*;
#(
  parameter int OPC_W   = 4,
  parameter int UADDR_W = 6,
  parameter int CTRL_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      instrValid,
  input  logic [OPC_W-1:0]          opcode,
  input  logic [FLAG_COUNT-1:0]     aluFlags,
  input  logic                      storeWrEn,
  input  logic [UADDR_W-1:0]        storeWrAddr,
  input  logic [CTRL_W+UADDR_W+3:0] storeWrData,
  input  logic                      mapWrEn,
  input  logic [OPC_W-1:0]          mapWrAddr,
  input  logic [UADDR_W-1:0]        mapWrData,
  output logic [CTRL_W-1:0]         ctrlWord,
  output logic                      instrDone
);

  seqStrobe_t        strobe;
  seqOp_e            seqOp;
  logic [1:0]        flagSel;
  logic [CTRL_W-1:0] ctrlField;

  useq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .instrValid (instrValid),
    .aluFlags   (aluFlags),
    .seqOp      (seqOp),
    .flagSel    (flagSel),
    .strobe     (strobe),
    .instrDone  (instrDone)
  );

  useq_dp #(.OPC_W(OPC_W), .UADDR_W(UADDR_W), .CTRL_W(CTRL_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .opcode      (opcode),
    .storeWrEn   (storeWrEn),
    .storeWrAddr (storeWrAddr),
    .storeWrData (storeWrData),
    .mapWrEn     (mapWrEn),
    .mapWrAddr   (mapWrAddr),
    .mapWrData   (mapWrData),
    .seqOp       (seqOp),
    .flagSel     (flagSel),
    .ctrlField   (ctrlField)
  );

  // R8 / R10: control bits reach the datapath only while a routine runs
  assign ctrlWord = strobe.drive ? ctrlField : '0;

  // R6: the done pulse comes with a driven control word
  p_done_driven_r6: assert property (@(posedge clk) disable iff (rst)
    instrDone |-> strobe.drive);

endmodule

// File: tb/micro_sequencer_tb.sv
module micro_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [2:0]  aluFlags = '0;
  logic        storeWrEn = 1'b0;
  logic [5:0]  storeWrAddr = '0;
  logic [17:0] storeWrData = '0;
  logic        mapWrEn = 1'b0;
  logic [3:0]  mapWrAddr = '0;
  logic [5:0]  mapWrData = '0;
  logic [7:0]  ctrlWord;
  logic        instrDone;

  always #5 clk = ~clk;

  micro_sequencer u_dut (
    .clk(clk), .rst(rst), .instrValid(instrValid), .opcode(opcode),
    .aluFlags(aluFlags), .storeWrEn(storeWrEn), .storeWrAddr(storeWrAddr),
    .storeWrData(storeWrData), .mapWrEn(mapWrEn), .mapWrAddr(mapWrAddr),
    .mapWrData(mapWrData), .ctrlWord(ctrlWord), .instrDone(instrDone)
  );

  int    nRun = 0, nFail = 0, cycles = 0;
  bit    cmpOn = 1'b0, ended = 1'b0;
  string phase = "R1";

  // Behavioural reference: store/table images, state 0 prime, 1 run, 2 idle
  logic [17:0] storeMdl [64];
  logic [5:0]  mapMdl [16];
  int          mState = 0;
  logic [5:0]  mPc = '0;

  function automatic logic [17:0] mk(input logic [1:0] s, input logic [1:0] f,
                                     input logic [5:0] t, input logic [7:0] c);
    return {c, t, f, s};
  endfunction

  always @(posedge clk) begin
    logic [17:0] w;
    logic        hit;
    w = storeMdl[mPc];
    case (w[3:2])
      2'b00:   hit = aluFlags[0];
      2'b01:   hit = aluFlags[1];
      2'b10:   hit = aluFlags[2];
      default: hit = 1'b0;
    endcase
    if (rst) begin
      mState = 0; mPc = '0;
    end else if (mState == 0) begin
      mState = 1;
    end else if (mState == 1) begin
      case (w[1:0])
        2'b00: mPc = mPc + 6'd1;
        2'b01: mPc = w[9:4];
        2'b10: mPc = hit ? w[9:4] : mPc + 6'd1;
        default: if (instrValid) mPc = mapMdl[opcode]; else mState = 2;
      endcase
    end else if (instrValid) begin
      mPc = mapMdl[opcode]; mState = 1;
    end
    if (storeWrEn) storeMdl[storeWrAddr] = storeWrData;
    if (mapWrEn)   mapMdl[mapWrAddr] = mapWrData;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference comparison every cycle
  always @(negedge clk) begin
    if (cmpOn && !ended) begin
      logic [7:0] eCtrl;
      logic       eDone;
      eCtrl = (mState == 1) ? storeMdl[mPc][17:10] : 8'h00;
      eDone = (mState == 1) && (storeMdl[mPc][1:0] == 2'b11);
      chk(ctrlWord == eCtrl && instrDone == eDone, phase,
          {ctrlWord, 3'b0, instrDone}, {eCtrl, 3'b0, eDone});
    end
  end

  task automatic finishRun();
    ended = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !ended) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  task automatic ldStore(input logic [5:0] a, input logic [17:0] d);
    @(negedge clk); storeWrEn = 1'b1; storeWrAddr = a; storeWrData = d;
    @(negedge clk); storeWrEn = 1'b0;
  endtask

  task automatic ldMap(input logic [3:0] a, input logic [5:0] d);
    @(negedge clk); mapWrEn = 1'b1; mapWrAddr = a; mapWrData = d;
    @(negedge clk); mapWrEn = 1'b0;
  endtask

  task automatic issue(input logic [3:0] opc, input logic [2:0] flg, input int gap);
    @(negedge clk); opcode = opc; aluFlags = flg; instrValid = 1'b1;
    @(negedge clk); instrValid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) storeMdl[i] = '0;
    for (int i = 0; i < 16; i++) mapMdl[i] = '0;
    repeat (2) @(negedge clk);
    cmpOn = 1'b1;
    // R10: program preloaded while reset is held
    phase = "R10";
    ldStore(0,  mk(2'b11, 2'b00, 6'd0,  8'h01));  // fetch: last word
    ldStore(8,  mk(2'b00, 2'b00, 6'd0,  8'h10));
    ldStore(9,  mk(2'b01, 2'b00, 6'd12, 8'h11));
    ldStore(10, mk(2'b11, 2'b00, 6'd0,  8'hEE));
    ldStore(12, mk(2'b11, 2'b00, 6'd0,  8'h12));
    ldStore(16, mk(2'b10, 2'b00, 6'd20, 8'h20));
    ldStore(17, mk(2'b11, 2'b00, 6'd0,  8'h21));
    ldStore(20, mk(2'b11, 2'b00, 6'd0,  8'h22));
    ldStore(24, mk(2'b10, 2'b01, 6'd28, 8'h30));
    ldStore(25, mk(2'b10, 2'b11, 6'd29, 8'h31));
    ldStore(26, mk(2'b11, 2'b00, 6'd0,  8'h32));
    ldStore(28, mk(2'b10, 2'b10, 6'd31, 8'h33));
    ldStore(29, mk(2'b11, 2'b00, 6'd0,  8'h35));
    ldStore(31, mk(2'b01, 2'b00, 6'd25, 8'h36));
    ldStore(40, mk(2'b11, 2'b00, 6'd0,  8'h40));
    ldStore(63, mk(2'b00, 2'b00, 6'd0,  8'h63));
    for (int i = 0; i < 16; i++) ldMap(4'(i), 6'd0);
    ldMap(1, 6'd8); ldMap(2, 6'd16); ldMap(3, 6'd24);
    ldMap(4, 6'd40); ldMap(5, 6'd63);

    phase = "R1";
    @(negedge clk);
    chk(ctrlWord == 8'h00 && !instrDone, "R1 reset", ctrlWord, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ctrlWord == 8'h01 && instrDone, "R1 fetch at 0 / R6", ctrlWord, 8'h01);

    phase = "R8";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ctrlWord == 8'h00 && !instrDone, "R8 idle", ctrlWord, 0);
    end

    phase = "R2/R3/R6";
    issue(1, 3'b000, 5);
    phase = "R4 zero";
    issue(2, 3'b001, 4);
    phase = "R5 zero clear";
    issue(2, 3'b110, 4);
    phase = "R4 carry/negative";
    issue(3, 3'b110, 6);
    phase = "R5 carry clear, selector 11";
    issue(3, 3'b101, 6);
    phase = "R4 carry, R5 negative clear";
    issue(3, 3'b010, 6);

    // R9: stray valid mid-routine is ignored
    phase = "R9";
    @(negedge clk); opcode = 4'd1; aluFlags = 3'b000; instrValid = 1'b1;
    @(negedge clk); opcode = 4'd4;
    @(negedge clk); instrValid = 1'b0; opcode = 4'd0;
    repeat (4) @(negedge clk);

    // R7: valid held, back-to-back dispatch with no idle cycle
    phase = "R7";
    @(negedge clk); opcode = 4'd4; instrValid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(ctrlWord == 8'h40 && instrDone, "R7 back-to-back", ctrlWord, 8'h40);
    end
    opcode = 4'd1;
    repeat (6) @(negedge clk);
    instrValid = 1'b0;
    repeat (4) @(negedge clk);

    // R11: routine at top address wraps into fetch
    phase = "R11";
    issue(5, 3'b000, 0);
    chk(ctrlWord == 8'h63, "R11 top word", ctrlWord, 8'h63);
    @(negedge clk);
    chk(ctrlWord == 8'h01 && instrDone, "R11 wrap to 0", ctrlWord, 8'h01);
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule